// File: doc/BRIEF.md
# Branch Resolution Unit with Single Delay Slot

This unit decides where instruction fetch goes next in a five-stage in-order pipeline. The condition tests are kept simple so that they fit early in the execute stage: two-register equality and inequality, a whole-register zero or non-zero test, and a sign-bit test. Register-indirect jumps use the same path and take their target from the forwarded first operand. Direct jumps are recognised in decode, and their target is formed from the upper bits of the sequential PC and the index field.

Every branch or jump is followed by exactly one delay-slot instruction, which runs whatever the outcome. A "likely" flavour of the conditional branches keeps that slot only when the branch is taken. When the branch is not taken, the unit raises an annul strobe that turns the slot into a bubble. There is no prediction: fetch keeps running sequentially until the unit issues a redirect.

The outputs are registered. A decision made from the inputs of one cycle appears on `redirect`, `next_pc` and `annul` in the next cycle. Fetch uses that as its address in the following fetch, which gives a branch latency of one cycle, and the delay slot hides it.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `redirect` and `annul` read 0 and `next_pc` reads 0.
- R2: A decision made from the inputs sampled at a clock edge appears on the outputs right after that edge, one cycle of latency. `next_pc` reads 0 in every cycle in which `redirect` is 0.
- R3: `ex_op` uses this encoding: 0 none, 1 taken when rs equals rt, 2 taken when rs differs from rt, 3 taken when rs is all zero, 4 taken when rs is not all zero, 5 taken when bit XLEN-1 of rs is 1, 6 taken when bit XLEN-1 of rs is 0, 7 register-indirect jump.
- R4: A taken conditional branch redirects to ex_pc + 4 plus the 16-bit `ex_offset`, sign-extended and shifted left by two bits.
- R5: A register-indirect jump is always taken and redirects to `ex_rs_val` unchanged. `ex_likely` has no effect on it.
- R6: When `id_jump` is 1, the unit redirects to the upper XLEN-28 bits of id_pc + 4, followed by the 26-bit `id_index`, followed by two zero bits.
- R7: A taken likely branch redirects and does not annul. A plain conditional branch never annuls, whether taken or not.
- R8: A likely branch that is not taken raises `annul` for one cycle and does not redirect.
- R9: When a likely branch in execute is found not taken, a direct jump presented in decode in the same cycle is dropped: no redirect follows.
- R10: Any execute-stage input presented in a cycle in which `annul` is 1 belongs to the annulled slot and is ignored: neither a redirect nor an annul follows.
- R11: A taken branch or indirect jump in execute wins over a direct jump in decode in the same cycle. A plain branch that is not taken lets that direct jump redirect.
- R12: With `ex_valid` at 0 or `ex_op` at 0, execute-stage operands cause no redirect and no annul.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_jump | input | 1 | Decode stage holds a direct jump |
| id_pc | input | XLEN | PC of the decode-stage instruction |
| id_index | input | 26 | Index field of the direct jump |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_op | input | 3 | Branch kind in execute (encoding in R3) |
| ex_likely | input | 1 | Conditional branch is the likely flavour |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| ex_offset | input | 16 | Branch offset in words |
| ex_rs_val | input | XLEN | Forwarded first operand |
| ex_rt_val | input | XLEN | Forwarded second operand |
| redirect | output | 1 | Fetch must load `next_pc` |
| next_pc | output | XLEN | Redirect target, 0 when idle |
| annul | output | 1 | Slot instruction becomes a bubble |

## Verification
Each condition kind is driven with operands on both sides of its test: equal and unequal pairs, zero against the smallest non-zero and the sign-bit-only value, and the largest positive value against all ones. This separates a swapped comparison from a correct one. Forward and backward offsets, and a jump whose PC + 4 carries into the upper bits, separate correct sign extension and carry from truncation. Decode jumps are paired with taken, plain not-taken and likely not-taken branches in the same cycle, and instructions are placed in the cycle right after an annul. These patterns separate the priority and gating rules from a design that resolves each stage on its own.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int BR_OP_W = 3;
  localparam int BR_OP_N = 1 << BR_OP_W;

  typedef enum logic [BR_OP_W-1:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NE   = 3'd2,
    BR_ZERO = 3'd3,
    BR_NZ   = 3'd4,
    BR_NEG  = 3'd5,
    BR_NNEG = 3'd6,
    BR_JREG = 3'd7
  } br_op_e;

  // Decision handed to the output register stage
  typedef struct packed {
    logic take_ex;
    logic take_id;
    logic kill_slot;
  } br_dec_t;

endpackage

// File: rtl/bru_cond.sv
// Fast condition tests: only equality, whole-word zero and sign bit.
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [BR_OP_W-1:0] op,
  input  logic [XLEN-1:0]    rs,
  input  logic [XLEN-1:0]    rt,
  output logic               taken,
  output logic               is_ind
);

  logic             same;
  logic             rs_zero;
  logic             rs_sign;
  logic [BR_OP_N-1:0] hit;

  assign same    = (rs == rt);
  assign rs_zero = (rs == '0);
  assign rs_sign = rs[XLEN-1];

  // One hit line per encoding; the op code selects among them.
  for (genvar g = 0; g < BR_OP_N; g++) begin : g_hit
    if (g == int'(BR_EQ)) begin : g_eq
      assign hit[g] = same;
    end else if (g == int'(BR_NE)) begin : g_ne
      assign hit[g] = !same;
    end else if (g == int'(BR_ZERO)) begin : g_z
      assign hit[g] = rs_zero;
    end else if (g == int'(BR_NZ)) begin : g_nz
      assign hit[g] = !rs_zero;
    end else if (g == int'(BR_NEG)) begin : g_neg
      assign hit[g] = rs_sign;
    end else if (g == int'(BR_NNEG)) begin : g_nneg
      assign hit[g] = !rs_sign;
    end else if (g == int'(BR_JREG)) begin : g_jr
      assign hit[g] = 1'b1;
    end else begin : g_none
      assign hit[g] = 1'b0;
    end
  end

  assign taken  = hit[op];
  assign is_ind = (op == BR_JREG);

endmodule

// File: rtl/bru_target.sv
// Target arithmetic for PC-relative branches and decode-stage direct jumps.
module bru_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  ex_pc,
  input  logic [OFF_W-1:0] ex_offset,
  input  logic [XLEN-1:0]  id_pc,
  input  logic [IDX_W-1:0] id_index,
  output logic [XLEN-1:0]  br_target,
  output logic [XLEN-1:0]  jmp_target
);

  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int UP_W  = XLEN - IDX_W - 2;

  logic [XLEN-1:0]      rel;
  logic [UP_W-1:0]      pc4_upper;
  logic [XLEN-UP_W-1:0] pc4_low_unused;

  assign rel       = {{EXT_W{ex_offset[OFF_W-1]}}, ex_offset, 2'b00};
  assign br_target = ex_pc + XLEN'(4) + rel;

  assign {pc4_upper, pc4_low_unused} = id_pc + XLEN'(4);
  assign jmp_target = {pc4_upper, id_index, 2'b00};

endmodule

// File: rtl/bru_select.sv
// Priority between stages and the registered output stage.
module bru_select
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_live,
  input  logic            ex_taken,
  input  logic            ex_is_ind,
  input  logic            ex_likely,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] ind_target,
  input  logic            id_jump,
  input  logic [XLEN-1:0] jmp_target,
  output logic            redirect_q,
  output logic [XLEN-1:0] next_pc_q,
  output logic            annul_q
);

  br_dec_t         dec;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    dec.take_ex   = ex_live && (ex_is_ind || ex_taken);
    dec.kill_slot = ex_live && !ex_is_ind && ex_likely && !ex_taken;
    // The decode instruction is the slot of the execute branch: it loses to
    // a taken transfer and vanishes when the slot is annulled.
    dec.take_id   = id_jump && !dec.take_ex && !dec.kill_slot;

    if (dec.take_ex) begin
      pc_d = ex_is_ind ? ind_target : br_target;
    end else if (dec.take_id) begin
      pc_d = jmp_target;
    end else begin
      pc_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_q <= 1'b0;
      next_pc_q  <= '0;
      annul_q    <= 1'b0;
    end else begin
      redirect_q <= dec.take_ex || dec.take_id;
      next_pc_q  <= pc_d;
      annul_q    <= dec.kill_slot;
    end
  end

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               id_jump,
  input  logic [XLEN-1:0]    id_pc,
  input  logic [IDX_W-1:0]   id_index,
  input  logic               ex_valid,
  input  logic [BR_OP_W-1:0] ex_op,
  input  logic               ex_likely,
  input  logic [XLEN-1:0]    ex_pc,
  input  logic [OFF_W-1:0]   ex_offset,
  input  logic [XLEN-1:0]    ex_rs_val,
  input  logic [XLEN-1:0]    ex_rt_val,
  output logic               redirect,
  output logic [XLEN-1:0]    next_pc,
  output logic               annul
);

  logic            taken;
  logic            is_ind;
  logic            ex_live;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  // While annul is high the execute stage holds the squashed slot.
  assign ex_live = ex_valid && !annul && (ex_op != BR_NONE);

  bru_cond #(.XLEN(XLEN)) u_cond (
    .op     (ex_op),
    .rs     (ex_rs_val),
    .rt     (ex_rt_val),
    .taken  (taken),
    .is_ind (is_ind)
  );

  bru_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
    .ex_pc      (ex_pc),
    .ex_offset  (ex_offset),
    .id_pc      (id_pc),
    .id_index   (id_index),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  bru_select #(.XLEN(XLEN)) u_select (
    .clk        (clk),
    .rst        (rst),
    .ex_live    (ex_live),
    .ex_taken   (taken),
    .ex_is_ind  (is_ind),
    .ex_likely  (ex_likely),
    .br_target  (br_target),
    .ind_target (ex_rs_val),
    .id_jump    (id_jump),
    .jmp_target (jmp_target),
    .redirect_q (redirect),
    .next_pc_q  (next_pc),
    .annul_q    (annul)
  );

endmodule

// File: rtl/branch_resolve_unit_chk.sv
module branch_resolve_unit_chk
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               id_jump,
  input logic               ex_valid,
  input logic [BR_OP_W-1:0] ex_op,
  input logic               ex_likely,
  input logic [XLEN-1:0]    ex_rs_val,
  input logic               redirect,
  input logic [XLEN-1:0]    next_pc,
  input logic               annul
);

  AST_IDLE_PC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> next_pc == '0); // R2

  AST_ANNUL_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    annul |-> !redirect); // R8

  AST_ANNUL_GAP: assert property (@(posedge clk) disable iff (rst)
    annul |=> !annul); // R10

  AST_IND_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_op == BR_JREG && !annul) |=>
      (redirect && next_pc == $past(ex_rs_val))); // R5

  AST_PLAIN_NO_ANNUL: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_likely) |=> !annul); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ex_valid && !id_jump) |=> (!redirect && !annul)); // R12

  AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (id_jump && !ex_valid) |=> (redirect && next_pc[1:0] == 2'b00)); // R6

endmodule

bind branch_resolve_unit branch_resolve_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .id_jump   (id_jump),
  .ex_valid  (ex_valid),
  .ex_op     (ex_op),
  .ex_likely (ex_likely),
  .ex_rs_val (ex_rs_val),
  .redirect  (redirect),
  .next_pc   (next_pc),
  .annul     (annul)
);

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
  import bru_pkg::*;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            id_jump = 1'b0;
  logic [31:0]     id_pc = '0;
  logic [25:0]     id_index = '0;
  logic            ex_valid = 1'b0;
  logic [2:0]      ex_op = 3'd0;
  logic            ex_likely = 1'b0;
  logic [31:0]     ex_pc = '0;
  logic [15:0]     ex_offset = '0;
  logic [31:0]     ex_rs_val = '0;
  logic [31:0]     ex_rt_val = '0;
  logic            redirect;
  logic [31:0]     next_pc;
  logic            annul;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic        rd;
    logic        an;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic model_annul = 1'b0;

  always #2 clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN)) u_branch_resolve_unit (
    .clk(clk), .rst(rst), .id_jump(id_jump), .id_pc(id_pc), .id_index(id_index),
    .ex_valid(ex_valid), .ex_op(ex_op), .ex_likely(ex_likely), .ex_pc(ex_pc),
    .ex_offset(ex_offset), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
    .redirect(redirect), .next_pc(next_pc), .annul(annul)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and queue the outcome the requirements predict.
  task automatic step(input logic ij, input logic [31:0] ipc, input logic [25:0] idx,
                      input logic ev, input logic [2:0] op, input logic lk,
                      input logic [31:0] epc, input logic [15:0] off,
                      input logic [31:0] rs, input logic [31:0] rt, input string tag);
    exp_t e;
    logic live, cond, ind, tex, kill, tid;
    logic [31:0] pc4;
    @(negedge clk);
    id_jump = ij; id_pc = ipc; id_index = idx; ex_valid = ev; ex_op = op;
    ex_likely = lk; ex_pc = epc; ex_offset = off; ex_rs_val = rs; ex_rt_val = rt;
    live = ev && !model_annul && (op != 3'd0);
    case (op)
      3'd1: cond = (rs == rt);
      3'd2: cond = (rs != rt);
      3'd3: cond = (rs == 32'd0);
      3'd4: cond = (rs != 32'd0);
      3'd5: cond = rs[31];
      3'd6: cond = !rs[31];
      default: cond = 1'b0;
    endcase
    ind  = (op == 3'd7);
    tex  = live && (ind || cond);
    kill = live && !ind && lk && !cond;
    tid  = ij && !tex && !kill;
    pc4  = ipc + 32'd4;
    e.rd = tex || tid;
    e.an = kill;
    if (tex) e.pc = ind ? rs : epc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    else if (tid) e.pc = {pc4[31:28], idx, 2'b00};
    else e.pc = 32'd0;
    e.tag = tag;
    q.push_back(e);
    model_annul = kill;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'd0, 26'd0, 1'b0, 3'd0, 1'b0, 32'd0, 16'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic br(input logic [2:0] op, input logic lk, input logic [31:0] epc,
                    input logic [15:0] off, input logic [31:0] rs, input logic [31:0] rt,
                    input string tag);
    step(1'b0, 32'd0, 26'd0, 1'b1, op, lk, epc, off, rs, rt, tag);
  endtask

  // Monitor: compare each queued item just after the edge that produces it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "redirect", {31'd0, redirect}, {31'd0, e.rd});
        check(e.tag, "annul", {31'd0, annul}, {31'd0, e.an});
        check(e.tag, "next_pc", next_pc, e.pc);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "redirect", {31'd0, redirect}, 32'd0);
    check("R1", "annul", {31'd0, annul}, 32'd0);
    check("R1", "next_pc", next_pc, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "next_pc after release", next_pc, 32'd0);

    idle("R2");
    // R3 conditions, both outcomes of each
    br(BR_EQ,   1'b0, 32'h0040_0000, 16'h0010, 32'h1234, 32'h1234, "R3 eq taken");
    br(BR_EQ,   1'b0, 32'h0040_0000, 16'h0010, 32'h5, 32'h6, "R3 eq not");
    br(BR_NE,   1'b0, 32'h0040_0100, 16'hFFFE, 32'h5, 32'h6, "R4 ne back");
    br(BR_NE,   1'b0, 32'h0040_0100, 16'hFFFE, 32'h7, 32'h7, "R3 ne not");
    br(BR_ZERO, 1'b0, 32'h0040_0200, 16'h7FFF, 32'h0, 32'h9, "R4 zero fwd");
    br(BR_ZERO, 1'b0, 32'h0040_0200, 16'h0004, 32'h1, 32'h0, "R3 zero not");
    br(BR_NZ,   1'b0, 32'h0040_0300, 16'h0004, 32'h0, 32'h0, "R3 nz not");
    br(BR_NZ,   1'b0, 32'h0040_0300, 16'h8000, 32'h8000_0000, 32'h0, "R4 nz min off");
    br(BR_NEG,  1'b0, 32'h0040_0400, 16'h0001, 32'h8000_0000, 32'h0, "R3 neg taken");
    br(BR_NEG,  1'b0, 32'h0040_0400, 16'h0001, 32'h7FFF_FFFF, 32'h0, "R3 neg not");
    br(BR_NNEG, 1'b0, 32'h0040_0500, 16'h0002, 32'h7FFF_FFFF, 32'h0, "R3 nneg taken");
    br(BR_NNEG, 1'b0, 32'h0040_0500, 16'h0002, 32'hFFFF_FFFF, 32'h0, "R3 nneg not");
    // R5 indirect, likely bit set but ignored
    br(BR_JREG, 1'b1, 32'h0040_0600, 16'h0000, 32'h0040_1235, 32'h0, "R5 jreg");
    idle("R2");
    // R6 direct jump with carry into upper bits
    step(1'b1, 32'h1FFF_FFFC, 26'h3FF_FFFF, 1'b0, 3'd0, 1'b0, 0, 0, 0, 0, "R6 jump carry");
    step(1'b1, 32'h0040_0000, 26'h012_3456, 1'b0, 3'd0, 1'b0, 0, 0, 0, 0, "R6 jump");
    // R7 likely taken, plain not-taken never annuls
    br(BR_EQ, 1'b1, 32'h0040_0700, 16'h0008, 32'h3, 32'h3, "R7 likely taken");
    br(BR_NE, 1'b0, 32'h0040_0700, 16'h0008, 32'h3, 32'h3, "R7 plain not");
    // R8 + R9: likely not taken with a jump in decode
    step(1'b1, 32'h0040_0804, 26'h000_0100, 1'b1, BR_EQ, 1'b1, 32'h0040_0800, 16'h0008,
         32'h1, 32'h2, "R9 likely not with jump");
    // R10: slot in execute during annul is ignored
    br(BR_EQ, 1'b0, 32'h0040_0804, 16'h0040, 32'h4, 32'h4, "R10 slot ignored");
    br(BR_EQ, 1'b0, 32'h0040_0808, 16'h0040, 32'h4, 32'h4, "R10 after gap");
    // R8 back to back likely not taken: second falls in annul cycle
    br(BR_NZ, 1'b1, 32'h0040_0900, 16'h0004, 32'h0, 32'h0, "R8 likely not");
    br(BR_NZ, 1'b1, 32'h0040_0904, 16'h0004, 32'h0, 32'h0, "R10 likely in gap");
    // R10: indirect jump in annul cycle is ignored too
    br(BR_NEG, 1'b1, 32'h0040_0A00, 16'h0004, 32'h1, 32'h0, "R8 likely not 2");
    br(BR_JREG, 1'b0, 32'h0040_0A04, 16'h0000, 32'h0000_1000, 32'h0, "R10 jreg in gap");
    // R11 priority
    step(1'b1, 32'h0040_0B04, 26'h000_0200, 1'b1, BR_NE, 1'b0, 32'h0040_0B00, 16'h0010,
         32'h1, 32'h2, "R11 ex wins");
    step(1'b1, 32'h0040_0C04, 26'h000_0300, 1'b1, BR_NE, 1'b0, 32'h0040_0C00, 16'h0010,
         32'h2, 32'h2, "R11 jump after plain not");
    // R12 invalid or none
    step(1'b0, 0, 0, 1'b0, BR_EQ, 1'b1, 32'h0040_0D00, 16'h0010, 32'h9, 32'h9, "R12 not valid");
    step(1'b0, 0, 0, 1'b1, BR_NONE, 1'b1, 32'h0040_0D00, 16'h0010, 32'h9, 32'h8, "R12 none");
    idle("R2");
    idle("R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule